// File: doc/BRIEF.md
# Synchronous Burst Memory Clock and Latency Sequencer

This block drives the timing side of a read from a synchronous burst NOR-style memory. When a read is requested it asserts a chip select and derives a memory clock from the system clock. The period of that memory clock is a programmable whole number of system clock cycles. It then waits a programmable first-data latency, counted in memory clock periods. After that it pulses a data-valid strobe once per memory clock period for the requested number of beats. When the burst ends it releases chip select and holds the bus idle for a programmable number of system clock cycles before it accepts another request.

All timing comes from one 32-bit configuration word, captured when a read starts. The divide field sits in bits 23:20, the latency field in bits 27:24 and the turnaround field in bits 19:16. The remaining bits, including the access-mode pair at 29:28, do not affect this block. A ready flag tells the requester when a new read may be issued.

Top module: `burst_clk_seq`

## Requirements
- R1: While reset is held and right after it, ready is 1 and chipSel, memClk and dataValid are 0.
- R2: A startReq sampled high on a clock edge while ready is 1 starts a read. In the next cycle chipSel is 1 and ready is 0. memClk is still 0 in that first chip-select cycle and rises in the cycle after it.
- R3: With a divide field N (bits 23:20) from 1 to 15, the memory clock period P is N+1 system cycles. In each period memClk is high for the first floor(P/2) cycles and low for the rest.
- R4: A divide field of 0 acts as 1, which gives a period of 2 cycles.
- R5: Number the chip-select cycles from 0. With a latency field L (bits 27:24), the first dataValid pulse falls in cycle (L+2)·P, so the latency is L+2 memory clock periods.
- R6: dataValid pulses for one cycle in cycles (L+2+j)·P for j = 0..B-1, where B is burstLen and a burstLen of 0 counts as 1. chipSel is high up to and including the last beat's cycle and is 0 from the next cycle on.
- R7: With a turnaround field T (bits 19:16), chipSel, memClk and ready stay 0 for exactly T+1 cycles after chip select falls. ready is 1 in the cycle after that.
- R8: A startReq while ready is 0 is ignored. It neither stretches nor restarts the read in progress.
- R9: The configuration word and burstLen are sampled only on the accepting edge. Changing them later has no effect on the running read, and bits outside 27:16, together with bits 29:28, never affect timing.
- R10: memClk is 0 whenever chipSel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timingCfg | input | 32 | Timing configuration word |
| startReq | input | 1 | Request to start a burst read |
| burstLen | input | LEN_W (8) | Number of data beats, 0 treated as 1 |
| memClk | output | 1 | Memory clock |
| chipSel | output | 1 | Chip select, active high |
| dataValid | output | 1 | One-cycle strobe per data beat |
| ready | output | 1 | High when idle and able to accept a start |

## Verification
Two events can fall in the same cycle. The last dataValid beat shares its cycle with the final chip-select cycle, and a startReq held high can meet the final turnaround cycle, where it must still be ignored, or the first ready cycle, where it must be taken. The bench holds startReq high across whole bursts and turnarounds. A behavioural cycle model predicts every output on every clock, so the exact edge where the drop-out and the re-acceptance happen is compared, not just the eventual outcome.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int TURN_LSB = 16;
  localparam int DIV_LSB  = 20;
  localparam int LAT_LSB  = 24;
  localparam int FIELD_W  = 4;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_BURST = 2'd1,
    SQ_TURN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;      // accepting edge: capture config, reset counters
    logic run;       // chip select phase
    logic turnLoad;  // last beat: load turnaround counter
    logic turning;   // turnaround phase
  } seqStrb_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     startReq,
  input  logic     lastBeat,
  input  logic     turnDone,
  output seqStrb_t strb,
  output logic     chipSel,
  output logic     ready
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      SQ_IDLE:  if (startReq) stateNext = SQ_BURST;
      SQ_BURST: if (lastBeat) stateNext = SQ_TURN;
      SQ_TURN:  if (turnDone) stateNext = SQ_IDLE;
      default:  stateNext = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strb.load     = (state == SQ_IDLE) && startReq;
    strb.run      = (state == SQ_BURST);
    strb.turnLoad = (state == SQ_BURST) && lastBeat;
    strb.turning  = (state == SQ_TURN);
  end

  assign chipSel = (state == SQ_BURST);
  assign ready   = (state == SQ_IDLE);

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_BURST && !lastBeat) |=> (state == SQ_BURST)); // R8

  AST_TURN_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_TURN && !turnDone) |=> !ready); // R7

endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqStrb_t         strb,
  input  logic [31:0]      timingCfg,
  input  logic [LEN_W-1:0] burstLen,
  output logic             lastBeat,
  output logic             turnDone,
  output logic             memClk,
  output logic             dataValid
);

  localparam int PER_W = LEN_W + 2;

  logic [FIELD_W-1:0] divR, latR, turnR;
  logic [LEN_W-1:0]   lenM1;
  logic [FIELD_W-1:0] ph, phNext;
  logic [PER_W-1:0]   per, perNext;
  logic               lead, leadNext;
  logic [FIELD_W-1:0] turnCnt;
  logic               memClkQ;

  logic [FIELD_W-1:0] divIn;
  logic [FIELD_W:0]   half;
  logic [PER_W-1:0]   firstPer, lastPer;
  logic               periodEnd, runNext, memClkNext;

  // Divide field 0 is reserved: fall back to the shortest legal period
  assign divIn = (timingCfg[DIV_LSB +: FIELD_W] == '0) ? FIELD_W'(1)
                                                       : timingCfg[DIV_LSB +: FIELD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divR  <= '1;
      latR  <= '1;
      turnR <= '1;
      lenM1 <= '0;
    end else if (strb.load) begin
      divR  <= divIn;
      latR  <= timingCfg[LAT_LSB +: FIELD_W];
      turnR <= timingCfg[TURN_LSB +: FIELD_W];
      lenM1 <= (burstLen == '0) ? '0 : burstLen - LEN_W'(1);
    end
  end

  // Period P = divR + 1; high for floor(P/2) cycles
  assign half      = ({1'b0, divR} + (FIELD_W+1)'(1)) >> 1;
  assign firstPer  = PER_W'(latR) + PER_W'(1);
  assign lastPer   = firstPer + PER_W'(lenM1);
  assign periodEnd = !lead && (ph == divR);

  assign dataValid = strb.run && periodEnd && (per >= firstPer) && (per <= lastPer);
  assign lastBeat  = strb.run && periodEnd && (per == lastPer);

  always_comb begin
    leadNext = lead;
    phNext   = ph;
    perNext  = per;
    if (strb.load) begin
      leadNext = 1'b1;
      phNext   = '0;
      perNext  = '0;
    end else if (strb.run) begin
      if (lead) begin
        leadNext = 1'b0;
      end else if (ph == divR) begin
        phNext  = '0;
        perNext = per + PER_W'(1);
      end else begin
        phNext = ph + FIELD_W'(1);
      end
    end
  end

  assign runNext    = strb.load || (strb.run && !lastBeat);
  assign memClkNext = runNext && !leadNext && ({1'b0, phNext} < half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead    <= 1'b0;
      ph      <= '0;
      per     <= '0;
      memClkQ <= 1'b0;
    end else begin
      lead    <= leadNext;
      ph      <= phNext;
      per     <= perNext;
      memClkQ <= memClkNext;
    end
  end

  assign memClk = memClkQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          turnCnt <= '0;
    else if (strb.turnLoad)              turnCnt <= turnR;
    else if (strb.turning && turnCnt != '0) turnCnt <= turnCnt - FIELD_W'(1);
  end

  assign turnDone = (turnCnt == '0);

  AST_MCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    memClk |-> strb.run); // R10

  AST_NO_CLK_IN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    strb.turning |-> !memClk); // R7

  AST_DV_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> !memClk); // R5

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.run |-> (ph <= divR)); // R3

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.run && !lastBeat) |=> $stable({divR, latR, turnR, lenM1})); // R9

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    strb.run |-> (divR != '0)); // R4

endmodule

// File: rtl/burst_clk_seq.sv
module burst_clk_seq
  import burst_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      timingCfg,
  input  logic             startReq,
  input  logic [LEN_W-1:0] burstLen,
  output logic             memClk,
  output logic             chipSel,
  output logic             dataValid,
  output logic             ready
);

  seqStrb_t strb;
  logic     lastBeat, turnDone;

  burst_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startReq (startReq),
    .lastBeat (lastBeat),
    .turnDone (turnDone),
    .strb     (strb),
    .chipSel  (chipSel),
    .ready    (ready)
  );

  burst_seq_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .timingCfg (timingCfg),
    .burstLen  (burstLen),
    .lastBeat  (lastBeat),
    .turnDone  (turnDone),
    .memClk    (memClk),
    .dataValid (dataValid)
  );

  AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!chipSel && !memClk && !dataValid)); // R1

  AST_DV_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> chipSel); // R6

endmodule

// File: tb/burst_clk_seq_test.sv
module burst_clk_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = 32'h0FFF_FFFF;
  logic        startReq = 1'b0;
  logic [7:0]  burstLen = 8'd1;
  logic        memClk, chipSel, dataValid, ready;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string curReq = "R1";

  // reference model state
  int mMode = 0;  // 0 idle, 1 burst, 2 turnaround
  int mC = 0, mP = 16, mL = 15, mB = 1, mT = 15, mTc = 0;

  always #4 clk = ~clk;  // 125 MHz

  burst_clk_seq uut (
    .clk(clk), .rst_n(rst_n), .timingCfg(cfg), .startReq(startReq),
    .burstLen(burstLen), .memClk(memClk), .chipSel(chipSel),
    .dataValid(dataValid), .ready(ready)
  );

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) mMode = 0;
    else begin
      case (mMode)
        0: if (startReq) begin
             mP = (cfg[23:20] == 0) ? 2 : int'(cfg[23:20]) + 1;
             mL = cfg[27:24];
             mT = cfg[19:16];
             mB = (burstLen == 0) ? 1 : int'(burstLen);
             mC = 0;
             mMode = 1;
           end
        1: if (mC == (mL + 1 + mB) * mP) begin mMode = 2; mTc = 0; end
           else mC++;
        default: if (mTc == mT) mMode = 0; else mTc++;
      endcase
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cmp(string tag, string sig, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: act=%b exp=%b", tag, sig, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic eCs, eRdy, eClk, eDv;
    eCs  = (mMode == 1);
    eRdy = (mMode == 0);
    eClk = eCs && mC >= 1 && ((mC - 1) % mP) < (mP / 2);
    eDv  = eCs && mC >= 1 && (mC % mP == 0) && (mC / mP >= mL + 2) && (mC / mP <= mL + 1 + mB);
    cmp((curReq == "R1") ? "R1" : "R7", "ready", ready, eRdy);
    cmp((curReq == "R1") ? "R1" : "R6", "chipSel", chipSel, eCs);
    cmp(eCs ? ((curReq == "R4") ? "R4" : "R3") : "R10", "memClk", memClk, eClk);
    cmp(curReq == "R2" ? "R2" : "R5", "dataValid", dataValid, eDv);
  end

  task automatic waitIdle();
    do @(negedge clk); while (mMode != 0);
  endtask

  task automatic burst(string tag, logic [31:0] c, logic [7:0] len, bit hold);
    curReq = tag;
    @(negedge clk);
    cfg = c; burstLen = len; startReq = 1'b1;
    @(negedge clk);
    if (!hold) startReq = 1'b0;
    waitIdle();
    startReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    burst("R2", 32'h0010_0000, 8'd4, 1'b0);   // N=1,L=0,T=0
    burst("R3", 32'h0FFF_FFFF, 8'd2, 1'b0);   // reset-value timing
    burst("R4", 32'h0103_0000, 8'd1, 1'b0);   // N=0 -> period 2, L=1, T=3
    burst("R6", 32'h0225_0000, 8'd0, 1'b0);   // odd period 3, len 0 -> 1 beat
    burst("R5", 32'h0532_0000, 8'd3, 1'b0);   // latency 7 periods of 4

    // R8: start held high across burst and turnaround, then one more burst
    curReq = "R8";
    @(negedge clk);
    cfg = 32'h0121_0000; burstLen = 8'd2; startReq = 1'b1;
    repeat (2) begin
      @(negedge clk);
      while (mMode != 0) @(negedge clk);
    end
    startReq = 1'b0;
    waitIdle();

    // R9: configuration changes mid-burst have no effect
    curReq = "R9";
    @(negedge clk);
    cfg = 32'h0342_0000; burstLen = 8'd3; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (5) @(negedge clk);
    cfg = 32'h0010_0000; burstLen = 8'd9;
    waitIdle();

    // R9: bits outside the timing fields do nothing
    burst("R9", 32'hF231_A5C3, 8'd2, 1'b0);
    burst("R9", 32'h3231_5A3C, 8'd2, 1'b0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule